// File: doc/BRIEF.md
# Microcoded Execution Datapath

This block is the execution half of a microprogrammed processor. Each clock cycle it takes one set of horizontal control bits. Those bits pick one register to drive onto the B bus. They set an ALU that combines the holding register H with that bus, and they choose a shift applied to the ALU result. Finally they name which registers capture the shifted value from the C bus. The same bits can also start a 32-bit word read or write, addressed by the word-address register, or a byte fetch addressed by the byte-address register. The sequencer and the control store that produce these bits sit outside the block. So does the memory.

The register set holds a word-address register (MAR), a memory data register (MDR), a byte program counter (PC), an 8-bit fetched-byte register (MBR), four pointer/scratch registers (SP, LV, CPP, TOS), a temporary (OPC) and H. Two status flags give the sign and zero state of the last ALU result. Microcode uses them to branch.

The memory side has no valid/ready handshake and no back-pressure. Every request is accepted, and the memory must return its data with a fixed latency of one cycle. Control and status pins are plain levels.

Top module: `ucode_datapath`

## Requirements
- R1: While reset is low, and at the first sample after it is released, all registers (MAR, MDR, PC, SP, LV, CPP, TOS, OPC, H, MBR) hold zero. The flags read 0 and no memory request is raised.
- R2: `ctl_bsel` selects the single B-bus source: 0 MDR, 1 PC, 2 MBR sign-extended, 3 MBR zero-extended, 4 SP, 5 LV, 6 CPP, 7 TOS, 8 OPC. Codes 9 to 15 put zero on the bus.
- R3: With code 3 the bus carries MBR in bits 7:0 with zeros above. With code 2, bit 7 of MBR is copied into bits 31:8.
- R4: `ctl_alu` bits are [5:4] function, [3] enable H, [2] enable B, [1] invert H, [0] carry-in. A disabled operand is zero, and inversion applies after enabling. Function 0 gives AND, 1 gives OR, 2 gives NOT of the B operand, and 3 gives H-operand + B-operand + carry-in. The carry-in affects only function 3.
- R5: `ctl_shift` applies to the ALU result: 0 and 3 pass it through, 1 shifts it left by 8 and fills with zeros, and 2 shifts it right by 1 while keeping the sign bit.
- R6: `ctl_cwr` bit i writes the shifter output into a register at the clock edge: 0 MAR, 1 MDR, 2 PC, 3 SP, 4 LV, 5 CPP, 6 TOS, 7 OPC, 8 H. Any number of bits may be set together. With no bit set, no register changes except through a memory completion.
- R7: At the same edge that writes the C-bus registers, `flag_n` takes bit 31 of the unshifted ALU result, and `flag_z` is set when that result is zero.
- R8: `ctl_rd` in cycle k raises `mem_rd` during cycle k+1, using the MAR value present in that cycle. MDR captures `mem_rdata` at the end of cycle k+1. That capture wins over a C-bus write to MDR in the same cycle.
- R9: `ctl_wr` in cycle k raises `mem_wr` during cycle k+1, with `mem_word_addr` equal to MAR and `mem_wdata` equal to MDR during that cycle.
- R10: `ctl_fetch` in cycle k raises `mem_fetch` during cycle k+1, with `mem_byte_addr` equal to PC. MBR captures `mem_byte` at the end of cycle k+1.
- R11: A word read and a word write are never requested in the same cycle. Doing so is a protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_alu | input | 6 | ALU function and operand controls |
| ctl_shift | input | 2 | Shifter mode |
| ctl_bsel | input | 4 | B-bus source code |
| ctl_cwr | input | 9 | C-bus write enables, one per register |
| ctl_rd | input | 1 | Start a word read at the end of this cycle |
| ctl_wr | input | 1 | Start a word write at the end of this cycle |
| ctl_fetch | input | 1 | Start a byte fetch at the end of this cycle |
| mem_word_addr | output | 32 | Word address (MAR) |
| mem_wdata | output | 32 | Write data (MDR) |
| mem_rd | output | 1 | Word read in progress this cycle |
| mem_wr | output | 1 | Word write in progress this cycle |
| mem_rdata | input | 32 | Read data, sampled at the end of a read cycle |
| mem_byte_addr | output | 32 | Byte address (PC) |
| mem_fetch | output | 1 | Byte fetch in progress this cycle |
| mem_byte | input | 8 | Fetched byte, sampled at the end of a fetch cycle |
| flag_n | output | 1 | Sign of the last ALU result |
| flag_z | output | 1 | Last ALU result was zero |

## Verification
Register writes and both flags are due one edge after the control bits are applied. Memory request pins are due one edge after the request bit. The returned word or byte lands in MDR or MBR one edge after that, two edges after the request. The bench applies each control set half a cycle before the rising edge. It advances its reference model at that edge and compares every output at the following falling edge, so each result is checked in the first cycle it is due. Registers with no direct pin are routed through the B bus, the ALU and the C bus into MAR, which adds exactly one edge that the model accounts for in the same way.

// File: rtl/dp_pkg.sv
package dp_pkg;
  // B-bus source codes (decoded by the source mux)
  localparam int unsigned BS_MDR   = 0;
  localparam int unsigned BS_PC    = 1;
  localparam int unsigned BS_MBR_S = 2;
  localparam int unsigned BS_MBR_U = 3;
  localparam int unsigned BS_SP    = 4;
  localparam int unsigned BS_LV    = 5;
  localparam int unsigned BS_CPP   = 6;
  localparam int unsigned BS_TOS   = 7;
  localparam int unsigned BS_OPC   = 8;
  localparam int unsigned BS_USED  = 9;

  // C-bus write-enable bit positions
  localparam int unsigned CW_MAR = 0;
  localparam int unsigned CW_MDR = 1;
  localparam int unsigned CW_PC  = 2;
  localparam int unsigned CW_SP  = 3;
  localparam int unsigned CW_LV  = 4;
  localparam int unsigned CW_CPP = 5;
  localparam int unsigned CW_TOS = 6;
  localparam int unsigned CW_OPC = 7;
  localparam int unsigned CW_H   = 8;
  localparam int unsigned CW_NUM = 9;

  typedef enum logic [1:0] {ALU_AND, ALU_OR, ALU_NOTB, ALU_ADD} alu_fn_e;

  typedef struct packed {
    alu_fn_e fn;
    logic    ena;
    logic    enb;
    logic    inva;
    logic    inc;
  } alu_ctl_t;

  typedef enum logic [1:0] {SH_PASS, SH_SLL8, SH_SRA1, SH_PASS_ALT} sh_mode_e;
endpackage

// File: rtl/dp_bsrc_mux.sv
module dp_bsrc_mux #(
  parameter int unsigned W     = 32,
  parameter int unsigned BW    = 8,
  parameter int unsigned SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     mdr,
  input  logic [W-1:0]     pc,
  input  logic [BW-1:0]    mbr,
  input  logic [W-1:0]     sp,
  input  logic [W-1:0]     lv,
  input  logic [W-1:0]     cpp,
  input  logic [W-1:0]     tos,
  input  logic [W-1:0]     opc,
  output logic [W-1:0]     bus_b
);
  localparam int unsigned NSRC = 1 << SEL_W;
  localparam int unsigned EXT  = W - BW;

  logic [W-1:0]    src   [NSRC];
  logic [W-1:0]    gated [NSRC];
  logic [NSRC-1:0] dec;

  assign dec = {{(NSRC-1){1'b0}}, 1'b1} << sel;

  always_comb begin
    for (int i = 0; i < NSRC; i++) src[i] = '0;
    src[dp_pkg::BS_MDR]   = mdr;
    src[dp_pkg::BS_PC]    = pc;
    src[dp_pkg::BS_MBR_S] = {{EXT{mbr[BW-1]}}, mbr};
    src[dp_pkg::BS_MBR_U] = {{EXT{1'b0}}, mbr};
    src[dp_pkg::BS_SP]    = sp;
    src[dp_pkg::BS_LV]    = lv;
    src[dp_pkg::BS_CPP]   = cpp;
    src[dp_pkg::BS_TOS]   = tos;
    src[dp_pkg::BS_OPC]   = opc;
  end

  // one AND-gate row per decoder output
  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign gated[g] = dec[g] ? src[g] : '0;
  end

  always_comb begin
    bus_b = '0;
    for (int i = 0; i < NSRC; i++) bus_b = bus_b | gated[i];
  end

  // R2: unused codes leave the bus at zero
  always_comb begin
    if (int'(sel) >= int'(dp_pkg::BS_USED)) begin
      p_unused_zero_r2: assert (bus_b == '0);
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]    h_in,
  input  logic [W-1:0]    b_in,
  input  dp_pkg::alu_ctl_t ctl,
  output logic [W-1:0]    y
);
  logic [W-1:0] opa;
  logic [W-1:0] opb;

  always_comb begin
    opa = ctl.ena ? h_in : '0;
    if (ctl.inva) opa = ~opa;
    opb = ctl.enb ? b_in : '0;
    unique case (ctl.fn)
      dp_pkg::ALU_AND:  y = opa & opb;
      dp_pkg::ALU_OR:   y = opa | opb;
      dp_pkg::ALU_NOTB: y = ~opb;
      default:          y = opa + opb + {{(W-1){1'b0}}, ctl.inc};
    endcase
  end
endmodule

// File: rtl/dp_shifter.sv
module dp_shifter #(
  parameter int unsigned W       = 32,
  parameter int unsigned SLL_AMT = 8
) (
  input  logic [W-1:0] d,
  input  logic [1:0]   mode,
  output logic [W-1:0] q
);
  always_comb begin
    unique case (dp_pkg::sh_mode_e'(mode))
      dp_pkg::SH_SLL8: q = d << SLL_AMT;
      dp_pkg::SH_SRA1: q = {d[W-1], d[W-1:1]};
      default:         q = d;
    endcase
  end
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int unsigned W       = 32,
  parameter int unsigned NC      = 9,
  parameter int unsigned MDR_IDX = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         cbus,
  input  logic [NC-1:0]        cwr,
  input  logic                 mdr_load,
  input  logic [W-1:0]         mdr_in,
  output logic [NC-1:0][W-1:0] q
);
  logic [W-1:0] r [NC];

  for (genvar g = 0; g < NC; g++) begin : g_reg
    if (g == MDR_IDX) begin : g_mdr
      // memory completion has priority over the C bus
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        r[g] <= '0;
        else if (mdr_load) r[g] <= mdr_in;
        else if (cwr[g])   r[g] <= cbus;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      r[g] <= '0;
        else if (cwr[g]) r[g] <= cbus;
      end
    end
    assign q[g] = r[g];
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr == '0 && !mdr_load) |=> $stable(q));

  p_mdr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mdr_load |=> (q[MDR_IDX] == $past(mdr_in)));
endmodule

// File: rtl/ucode_datapath.sv
module ucode_datapath #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BSEL_W = 4,
  parameter int unsigned NCW    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        ctl_alu,
  input  logic [1:0]        ctl_shift,
  input  logic [BSEL_W-1:0] ctl_bsel,
  input  logic [NCW-1:0]    ctl_cwr,
  input  logic              ctl_rd,
  input  logic              ctl_wr,
  input  logic              ctl_fetch,
  output logic [DATA_W-1:0] mem_word_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_byte_addr,
  output logic              mem_fetch,
  input  logic [BYTE_W-1:0] mem_byte,
  output logic              flag_n,
  output logic              flag_z
);
  import dp_pkg::*;

  logic [NCW-1:0][DATA_W-1:0] rq;
  logic [BYTE_W-1:0]          mbr_q;
  logic [DATA_W-1:0]          bus_b;
  logic [DATA_W-1:0]          alu_y;
  logic [DATA_W-1:0]          bus_c;
  alu_ctl_t                   actl;

  assign actl = alu_ctl_t'(ctl_alu);

  dp_bsrc_mux #(.W(DATA_W), .BW(BYTE_W), .SEL_W(BSEL_W)) u_bsrc (
    .sel   (ctl_bsel),
    .mdr   (rq[CW_MDR]),
    .pc    (rq[CW_PC]),
    .mbr   (mbr_q),
    .sp    (rq[CW_SP]),
    .lv    (rq[CW_LV]),
    .cpp   (rq[CW_CPP]),
    .tos   (rq[CW_TOS]),
    .opc   (rq[CW_OPC]),
    .bus_b (bus_b)
  );

  dp_alu #(.W(DATA_W)) u_alu (
    .h_in (rq[CW_H]),
    .b_in (bus_b),
    .ctl  (actl),
    .y    (alu_y)
  );

  dp_shifter #(.W(DATA_W), .SLL_AMT(BYTE_W)) u_shift (
    .d    (alu_y),
    .mode (ctl_shift),
    .q    (bus_c)
  );

  dp_regfile #(.W(DATA_W), .NC(NCW), .MDR_IDX(CW_MDR)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .cbus     (bus_c),
    .cwr      (ctl_cwr),
    .mdr_load (mem_rd),
    .mdr_in   (mem_rdata),
    .q        (rq)
  );

  // requests issue at the end of the cycle they are asked for
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_fetch <= 1'b0;
    end else begin
      mem_rd    <= ctl_rd;
      mem_wr    <= ctl_wr;
      mem_fetch <= ctl_fetch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mbr_q <= '0;
    else if (mem_fetch) mbr_q <= mem_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      flag_n <= alu_y[DATA_W-1];
      flag_z <= (alu_y == '0);
    end
  end

  assign mem_word_addr = rq[CW_MAR];
  assign mem_wdata     = rq[CW_MDR];
  assign mem_byte_addr = rq[CW_PC];

  p_rdwr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_rd && ctl_wr));

  p_rd_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd |=> mem_rd);

  p_wr_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> mem_wr);

  p_fetch_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fetch |=> (mbr_q == $past(mem_byte)));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_z == ($past(alu_y) == '0)));

  p_sign_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_n == $past(alu_y[DATA_W-1])));
endmodule

// File: tb/ucode_datapath_test.sv
module ucode_datapath_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ctl_alu = '0;
  logic [1:0]  ctl_shift = '0;
  logic [3:0]  ctl_bsel = '0;
  logic [8:0]  ctl_cwr = '0;
  logic        ctl_rd = 1'b0, ctl_wr = 1'b0, ctl_fetch = 1'b0;
  logic [31:0] mem_word_addr, mem_wdata, mem_rdata, mem_byte_addr;
  logic        mem_rd, mem_wr, mem_fetch, flag_n, flag_z;
  logic [7:0]  mem_byte;

  int checks = 0;
  int errors = 0;

  // control words: {fn[1:0], en_h, en_b, inv_h, carry}
  localparam logic [5:0] PASS_B = 6'b11_0100;
  localparam logic [5:0] ONE    = 6'b11_0001;
  localparam logic [5:0] ADD_HB = 6'b11_1100;
  localparam logic [5:0] INC_B  = 6'b11_0101;
  localparam logic [5:0] IDLE   = 6'b00_0000;

  always #10 clk = ~clk;

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A0000C3;
  endfunction

  function automatic logic [7:0] byte_of(input logic [31:0] a);
    return a[7:0] * 8'h1D + 8'h83;
  endfunction

  assign mem_rdata = word_of(mem_word_addr);
  assign mem_byte  = byte_of(mem_byte_addr);

  ucode_datapath uut (
    .clk(clk), .rst_n(rst_n), .ctl_alu(ctl_alu), .ctl_shift(ctl_shift),
    .ctl_bsel(ctl_bsel), .ctl_cwr(ctl_cwr), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr),
    .ctl_fetch(ctl_fetch), .mem_word_addr(mem_word_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
    .mem_byte_addr(mem_byte_addr), .mem_fetch(mem_fetch), .mem_byte(mem_byte),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  // reference state: index follows the write-enable bit order of R6
  logic [31:0] m_reg [9];
  logic [7:0]  m_mbr;
  logic        m_n, m_z, m_rd, m_wr, m_f;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "mar",   mem_word_addr, m_reg[0]);
    chk(tag, "mdr",   mem_wdata,     m_reg[1]);
    chk(tag, "pc",    mem_byte_addr, m_reg[2]);
    chk(tag, "rd",    {31'b0, mem_rd},    {31'b0, m_rd});
    chk(tag, "wr",    {31'b0, mem_wr},    {31'b0, m_wr});
    chk(tag, "fetch", {31'b0, mem_fetch}, {31'b0, m_f});
    chk(tag, "n",     {31'b0, flag_n},    {31'b0, m_n});
    chk(tag, "z",     {31'b0, flag_z},    {31'b0, m_z});
  endtask

  task automatic model_step(input logic [5:0] a, input logic [1:0] s,
                            input logic [3:0] b, input logic [8:0] c);
    logic [31:0] bus, lop, rop, res, shv, old_mar, old_pc;
    old_mar = m_reg[0];
    old_pc  = m_reg[2];
    case (b)
      4'd0: bus = m_reg[1];
      4'd1: bus = m_reg[2];
      4'd2: bus = 32'($signed(m_mbr));          // R3 sign-extended
      4'd3: bus = {24'h0, m_mbr};               // R3 zero-extended
      4'd4: bus = m_reg[3];
      4'd5: bus = m_reg[4];
      4'd6: bus = m_reg[5];
      4'd7: bus = m_reg[6];
      4'd8: bus = m_reg[7];
      default: bus = 32'h0;                      // R2
    endcase
    lop = a[3] ? m_reg[8] : 32'h0;
    if (a[1]) lop = ~lop;
    rop = a[2] ? bus : 32'h0;
    case (a[5:4])
      2'd0: res = lop & rop;
      2'd1: res = lop | rop;
      2'd2: res = ~rop;
      default: res = lop + rop + 32'(a[0]);
    endcase
    if (s == 2'd1)      shv = res * 256;
    else if (s == 2'd2) shv = 32'($signed(res) >>> 1);
    else                shv = res;
    for (int i = 0; i < 9; i++) if (c[i]) m_reg[i] = shv;
    if (m_rd) m_reg[1] = word_of(old_mar);
    if (m_f)  m_mbr = byte_of(old_pc);
    m_n = res[31];
    m_z = (res == 32'h0);
  endtask

  task automatic cyc(input logic [5:0] a, input logic [1:0] s, input logic [3:0] b,
                     input logic [8:0] c, input logic r, input logic w,
                     input logic f, input string tag);
    ctl_alu = a; ctl_shift = s; ctl_bsel = b; ctl_cwr = c;
    ctl_rd = r; ctl_wr = w; ctl_fetch = f;
    @(posedge clk);
    model_step(a, s, b, c);
    m_rd = r; m_wr = w; m_f = f;
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic dump_all(input string tag);
    for (int k = 0; k < 16; k++) cyc(PASS_B, 2'd0, 4'(k), 9'h001, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) m_reg[i] = '0;
    m_mbr = '0; m_n = 0; m_z = 0; m_rd = 0; m_wr = 0; m_f = 0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    compare_all("R1");

    // R6: multi-register load of 1 into H and MAR, then R8 read of word 1
    cyc(ONE, 2'd0, 4'd0, 9'h101, 0, 0, 0, "R6");
    cyc(IDLE, 2'd0, 4'd0, 9'h000, 1, 0, 0, "R8");
    cyc(IDLE, 2'd0, 4'd0, 9'h000, 0, 0, 0, "R8");
    // seed scratch registers with distinct values
    cyc(PASS_B, 2'd0, 4'd0, 9'h008, 0, 0, 0, "R2");
    cyc(ADD_HB, 2'd0, 4'd0, 9'h010, 0, 0, 0, "R4");
    cyc(PASS_B, 2'd1, 4'd4, 9'h020, 0, 0, 0, "R5");
    cyc(PASS_B, 2'd2, 4'd0, 9'h040, 0, 0, 0, "R5");
    cyc(6'b11_0010, 2'd0, 4'd0, 9'h080, 0, 0, 0, "R4");
    cyc(INC_B, 2'd0, 4'd4, 9'h004, 0, 0, 0, "R4");
    // R10 byte fetch, then every bus code observed through MAR (R2, R3)
    cyc(IDLE, 2'd0, 4'd0, 9'h000, 0, 0, 1, "R10");
    cyc(IDLE, 2'd0, 4'd0, 9'h000, 0, 0, 0, "R10");
    dump_all("R2");
    for (int k = 0; k < 6; k++) begin
      cyc(INC_B, 2'd0, 4'd1, 9'h004, 0, 0, 0, "R10");
      cyc(IDLE, 2'd0, 4'd0, 9'h000, 0, 0, 1, "R10");
      cyc(IDLE, 2'd0, 4'd0, 9'h000, 0, 0, 0, "R10");
      cyc(PASS_B, 2'd0, 4'd2, 9'h001, 0, 0, 0, "R3");
      cyc(PASS_B, 2'd0, 4'd3, 9'h001, 0, 0, 0, "R3");
    end
    // R4 R5 R7: sweep every ALU control word against every shift mode
    for (int f = 0; f < 64; f++)
      for (int s = 0; s < 4; s++)
        cyc(6'(f), 2'(s), 4'((f * 4 + s) % 9),
            (s == 2) ? 9'h101 : 9'h001, 0, 0, 0, "R4");
    // R6: one value into all nine registers, then read-back
    cyc(PASS_B, 2'd0, 4'd8, 9'h1FF, 0, 0, 0, "R6");
    dump_all("R6");
    cyc(ADD_HB, 2'd1, 4'd1, 9'h1FE, 0, 0, 0, "R6");
    // R6: no enables, busy ALU, nothing may move
    for (int k = 0; k < 8; k++) cyc(6'(k * 7), 2'(k), 4'(k), 9'h000, 0, 0, 0, "R6");
    dump_all("R6");
    // R8: address written in the request cycle, memory beats C write to MDR
    cyc(INC_B, 2'd0, 4'd7, 9'h001, 1, 0, 0, "R8");
    cyc(ONE, 2'd0, 4'd0, 9'h002, 0, 0, 0, "R8");
    cyc(IDLE, 2'd0, 4'd0, 9'h000, 1, 0, 0, "R8");
    cyc(INC_B, 2'd0, 4'd0, 9'h001, 1, 0, 0, "R8");
    cyc(IDLE, 2'd0, 4'd0, 9'h000, 0, 0, 0, "R8");
    // R9: write issue with MDR and MAR on the pins; R11 keeps rd and wr apart
    cyc(ONE, 2'd1, 4'd0, 9'h002, 0, 1, 0, "R9");
    cyc(IDLE, 2'd0, 4'd0, 9'h000, 0, 0, 0, "R9");
    cyc(IDLE, 2'd0, 4'd0, 9'h000, 0, 1, 1, "R9");
    cyc(IDLE, 2'd0, 4'd0, 9'h000, 0, 0, 0, "R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule